// File: doc/BRIEF.md
# SD SPI Single-Block Data Phase Engine

This block runs the data phase of one SD card block transfer in SPI mode, once the read or write command has already been accepted by the card. It drives a byte-wide SPI master through a request/acknowledge handshake and owns chip select for the whole data phase. Read data leaves on a valid/ready byte stream. Write data enters on a second valid/ready byte stream.

A read clocks fill bytes until the start token arrives. It then hands the block bytes downstream and drops the two checksum bytes. A write sends the start token, the block bytes and two fill bytes in place of the checksum. It then decodes the card's data-response token and waits out the busy period. Every transfer ends the same way: chip select is released, one trailing fill byte is clocked, and a single-cycle `done` pulse is raised with an error code beside it.

The block length is `BLK_LEN` for card data. When `start_short` is set it is `REG_LEN`, which is used for register reads. A run-time byte limit bounds both the token search and the busy wait.

Top module: `sd_blk_xfer`

## Requirements
- R1: After reset, `cs_n` is 1, and `spi_req`, `busy`, `done` and `rd_valid` are 0.
- R2: A read clocks 0xFF bytes and searches for the start token 0xFE. Any other byte received before the token is ignored and never reaches the read stream.
- R3: After the token, a read delivers exactly the block length in bytes, in order, on `rd_data`. The block length is `REG_LEN` when `start_short` was 1 at start, otherwise `BLK_LEN`. The read then clocks two more 0xFF bytes whose received values are discarded.
- R4: While a read data byte waits on `rd_valid` with `rd_ready` low, no new SPI byte is started and `rd_data` holds its value.
- R5: A write sends 0xFE, then the block bytes in the order taken from the write stream, then 0xFF, 0xFF. `spi_tx` is held stable while a request is pending.
- R6: After a write, one byte is read and masked with 0x1F. A masked value of 0x05 means accepted. 0x0B gives `err_code` 2 (checksum rejected). 0x0D gives `err_code` 3 (write failure). Any other value gives `err_code` 4. On any rejection, chip select is released at once, with no busy wait.
- R7: After an accepted write, 0xFF bytes are clocked while the received byte is 0x00. The wait ends on the first nonzero byte.
- R8: Every transfer ends by raising `cs_n` and then clocking exactly one 0xFF byte with `cs_n` high. `done` then pulses for exactly one cycle. `cs_n` stays low for every earlier byte of the transfer.
- R9: If `tmo_limit` is nonzero and the token search or busy wait receives `tmo_limit` non-matching bytes, the transfer ends with `err_code` 1. A nonzero limit ends the search or wait after exactly that many bytes. `tmo_limit` = 0 disables the limit.
- R10: `start` has no effect while `busy` is 1.
- R11: `err_code` is 0 for a good transfer. It holds its value from `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer when idle |
| start_wr | input | 1 | 1 = write, 0 = read (sampled with start) |
| start_short | input | 1 | 1 = use REG_LEN as block length |
| tmo_limit | input | TMO_W | Byte limit for token search / busy wait, 0 = none |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err_code | output | 3 | 0 ok, 1 timeout, 2 checksum reject, 3 write failure, 4 bad token |
| cs_n | output | 1 | Card chip select, active low |
| spi_req | output | 1 | Byte request to SPI master |
| spi_tx | output | 8 | Byte to shift out |
| spi_ack | input | 1 | SPI master finished the byte |
| spi_rx | input | 8 | Byte shifted in, valid with spi_ack |
| rd_valid | output | 1 | Read data byte valid |
| rd_data | output | 8 | Read data byte |
| rd_ready | input | 1 | Downstream accepts read byte |
| wr_valid | input | 1 | Write data byte valid |
| wr_data | input | 8 | Write data byte |
| wr_ready | output | 1 | Engine accepts write byte |

## Verification
Each SPI byte completes in the cycle where `spi_req` and `spi_ack` are both high. A new request can rise no earlier than the cycle after that. A received read byte appears on `rd_valid` one cycle after its acknowledge. `done` rises in the cycle after the acknowledge of the trailing byte, and `err_code` is settled by then. The bench's card model and stream agents change inputs on falling edges and log every byte as it is acknowledged. The bench compares the full byte log, the chip-select state of each byte and the delivered data with expected sequences built from the scenario. Results are read only once `done` is seen on a falling edge, and the next falling edge confirms that `done` has dropped.

// File: rtl/sd_xfer_pkg.sv
package sd_xfer_pkg;

   localparam logic [7:0] TOK_START = 8'hFE;
   localparam logic [7:0] FILL_BYTE = 8'hFF;
   localparam logic [4:0] RESP_ACCEPT = 5'h05;
   localparam logic [4:0] RESP_CRC_BAD = 5'h0B;
   localparam logic [4:0] RESP_WR_FAIL = 5'h0D;

   typedef enum logic [2:0] {
      XE_NONE    = 3'd0,
      XE_TIMEOUT = 3'd1,
      XE_CRC     = 3'd2,
      XE_WRITE   = 3'd3,
      XE_TOKEN   = 3'd4
   } xfer_err_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HUNT,
      ST_RDATA,
      ST_RCRC,
      ST_WTOK,
      ST_WDATA,
      ST_WCRC,
      ST_WRESP,
      ST_WBUSY,
      ST_REL
   } xfer_state_e;

endpackage

// File: rtl/sd_xfer_cnt.sv
module sd_xfer_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("sd_xfer_cnt: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (inc) q <= q + 1'b1;
   end
endmodule

// File: rtl/sd_xfer_respdec.sv
module sd_xfer_respdec
   import sd_xfer_pkg::*;
(
   input  logic [4:0] tok,
   output logic       accepted,
   output xfer_err_e  code
);
   always_comb begin
      accepted = (tok == RESP_ACCEPT);
      unique case (tok)
         RESP_ACCEPT:  code = XE_NONE;
         RESP_CRC_BAD: code = XE_CRC;
         RESP_WR_FAIL: code = XE_WRITE;
         default:      code = XE_TOKEN;
      endcase
   end
endmodule

// File: rtl/sd_blk_xfer.sv
module sd_blk_xfer
   import sd_xfer_pkg::*;
#(
   parameter int BLK_LEN = 512,
   parameter int REG_LEN = 16,
   parameter int TMO_W   = 16,
   parameter bit TMO_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_wr,
   input  logic             start_short,
   input  logic [TMO_W-1:0] tmo_limit,
   output logic             busy,
   output logic             done,
   output logic [2:0]       err_code,
   output logic             cs_n,
   output logic             spi_req,
   output logic [7:0]       spi_tx,
   input  logic             spi_ack,
   input  logic [7:0]       spi_rx,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   input  logic             rd_ready,
   input  logic             wr_valid,
   input  logic [7:0]       wr_data,
   output logic             wr_ready
);
   localparam int LEN_W = $clog2(BLK_LEN + 1);

   if (BLK_LEN < 2) begin : g_bad_blk
      $error("sd_blk_xfer: BLK_LEN must be at least 2");
   end
   if (REG_LEN < 1 || REG_LEN > BLK_LEN) begin : g_bad_reg
      $error("sd_blk_xfer: REG_LEN must lie in 1..BLK_LEN");
   end
   if (TMO_W < 1) begin : g_bad_tmo
      $error("sd_blk_xfer: TMO_W must be at least 1");
   end

   xfer_state_e state, state_n;
   xfer_err_e   err_q, err_n;
   logic        short_q;
   logic        xfer;
   logic        launch_ok;
   logic [7:0]  launch_byte;
   logic [LEN_W-1:0] idx_q, cur_len;
   logic [TMO_W-1:0] tmo_q;
   logic        last, tmo_hit, in_count, in_wait, st_chg;
   logic        resp_ok;
   xfer_err_e   resp_code;

   assign xfer     = spi_req && spi_ack;
   assign busy     = (state != ST_IDLE);
   assign err_code = err_q;
   assign st_chg   = (state_n != state);
   assign cur_len  = short_q ? LEN_W'(REG_LEN) : LEN_W'(BLK_LEN);
   assign last     = (idx_q == cur_len - 1'b1);
   assign in_count = (state == ST_RDATA) || (state == ST_RCRC) ||
                     (state == ST_WDATA) || (state == ST_WCRC);
   assign in_wait  = (state == ST_HUNT) || (state == ST_WBUSY);
   assign wr_ready = (state == ST_WDATA) && !spi_req;

   sd_xfer_cnt #(.W(LEN_W)) u_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_chg),
      .inc   (xfer && in_count),
      .q     (idx_q)
   );

   if (TMO_EN) begin : g_tmo
      sd_xfer_cnt #(.W(TMO_W)) u_tmo (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (st_chg),
         .inc   (xfer && in_wait),
         .q     (tmo_q)
      );
      assign tmo_hit = (tmo_limit != '0) &&
                       ({1'b0, tmo_q} + 1'b1 == {1'b0, tmo_limit});
   end else begin : g_no_tmo
      assign tmo_q   = '0;
      assign tmo_hit = 1'b0;
   end

   sd_xfer_respdec u_dec (
      .tok      (spi_rx[4:0]),
      .accepted (resp_ok),
      .code     (resp_code)
   );

   // byte to launch in the current state
   always_comb begin
      launch_byte = FILL_BYTE;
      launch_ok   = !spi_req && (state != ST_IDLE);
      unique case (state)
         ST_WTOK:  launch_byte = TOK_START;
         ST_WDATA: begin
            launch_byte = wr_data;
            launch_ok   = wr_ready && wr_valid;
         end
         ST_RDATA: launch_ok = !spi_req && !rd_valid;
         default:  ;
      endcase
   end

   // next state and error capture
   always_comb begin
      state_n = state;
      err_n   = err_q;
      unique case (state)
         ST_IDLE: if (start) begin
            state_n = start_wr ? ST_WTOK : ST_HUNT;
            err_n   = XE_NONE;
         end
         ST_HUNT: if (xfer) begin
            if (spi_rx == TOK_START) state_n = ST_RDATA;
            else if (tmo_hit) begin
               state_n = ST_REL;
               err_n   = XE_TIMEOUT;
            end
         end
         ST_RDATA: if (xfer && last) state_n = ST_RCRC;
         ST_RCRC:  if (xfer && idx_q[0]) state_n = ST_REL;
         ST_WTOK:  if (xfer) state_n = ST_WDATA;
         ST_WDATA: if (xfer && last) state_n = ST_WCRC;
         ST_WCRC:  if (xfer && idx_q[0]) state_n = ST_WRESP;
         ST_WRESP: if (xfer) begin
            if (resp_ok) state_n = ST_WBUSY;
            else begin
               state_n = ST_REL;
               err_n   = resp_code;
            end
         end
         ST_WBUSY: if (xfer) begin
            if (spi_rx != 8'h00) state_n = ST_REL;
            else if (tmo_hit) begin
               state_n = ST_REL;
               err_n   = XE_TIMEOUT;
            end
         end
         ST_REL:   if (xfer) state_n = ST_IDLE;
         default:  state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         err_q    <= XE_NONE;
         short_q  <= 1'b0;
         cs_n     <= 1'b1;
         spi_req  <= 1'b0;
         spi_tx   <= FILL_BYTE;
         rd_valid <= 1'b0;
         rd_data  <= '0;
         done     <= 1'b0;
      end else begin
         state <= state_n;
         err_q <= err_n;
         done  <= (state == ST_REL) && xfer;
         if (state == ST_IDLE && start) begin
            short_q <= start_short;
            cs_n    <= 1'b0;
         end
         if (state_n == ST_REL && state != ST_REL) cs_n <= 1'b1;
         if (launch_ok) begin
            spi_req <= 1'b1;
            spi_tx  <= launch_byte;
         end else if (xfer) begin
            spi_req <= 1'b0;
         end
         if (state == ST_RDATA && xfer) begin
            rd_valid <= 1'b1;
            rd_data  <= spi_rx;
         end else if (rd_valid && rd_ready) begin
            rd_valid <= 1'b0;
         end
      end
   end

   // R1: chip select is released whenever the engine is idle
   a_r1_idle_cs: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> cs_n);
   // R4: a waiting read byte holds and blocks the next SPI byte
   a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
   a_r4_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RDATA && rd_valid && !rd_ready && !spi_req) |=> !spi_req);
   // R5: transmit byte stays put while the master works on it
   a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx)));
   // R8: done comes with chip select high, nothing pending, for one cycle
   a_r8_done_cs: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && !spi_req));
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R11: error code only changes at start or when a transfer ends
   a_r11_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !start) |=> $stable(err_code));
endmodule

// File: tb/sd_blk_xfer_tb.sv
module sd_blk_xfer_tb;
   localparam int BLK = 512;
   localparam int REG = 16;
   localparam int TW  = 16;
   localparam int LOGN = 1100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, start_wr = 1'b0, start_short = 1'b0;
   logic [TW-1:0] tmo_limit = '0;
   logic busy, done, cs_n, spi_req, rd_valid, wr_ready;
   logic [2:0] err_code;
   logic [7:0] spi_tx, rd_data;
   logic spi_ack = 1'b0;
   logic [7:0] spi_rx = 8'h00;
   logic rd_ready = 1'b0;
   logic wr_valid = 1'b0;
   logic [7:0] wr_data = 8'h00;

   always #2 clk = ~clk;

   sd_blk_xfer #(.BLK_LEN(BLK), .REG_LEN(REG), .TMO_W(TW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_wr(start_wr),
      .start_short(start_short), .tmo_limit(tmo_limit), .busy(busy),
      .done(done), .err_code(err_code), .cs_n(cs_n), .spi_req(spi_req),
      .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready));

   int n_chk = 0, n_bad = 0;
   logic [7:0] scr [LOGN];
   logic [7:0] txl [LOGN];
   logic       csl [LOGN];
   int pos = 0;
   logic [7:0] exp_d [BLK];
   logic [7:0] got_d [BLK];
   int got_n = 0;
   logic [7:0] wsrc [BLK];
   int w_idx = 0;
   bit rd_block = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // card model: acknowledge requests with a short random delay
   initial begin
      int dly = 0;
      forever begin
         @(negedge clk);
         if (spi_ack) spi_ack = 1'b0;
         else if (spi_req) begin
            if (dly > 0) dly--;
            else begin
               spi_ack = 1'b1;
               spi_rx  = (pos < LOGN) ? scr[pos] : 8'hFF;
               if (pos < LOGN) begin
                  txl[pos] = spi_tx;
                  csl[pos] = cs_n;
               end
               pos++;
               dly = int'($urandom % 3);
            end
         end
      end
   end

   // read consumer
   initial begin
      forever begin
         @(negedge clk);
         rd_ready = !rd_block && ($urandom % 4 != 0);
         if (rd_valid && rd_ready) begin
            if (got_n < BLK) got_d[got_n] = rd_data;
            got_n++;
         end
      end
   end

   // write source
   initial begin
      bit pend = 0;
      forever begin
         @(negedge clk);
         if (pend) w_idx++;
         wr_valid = ($urandom % 4 != 0);
         wr_data  = wsrc[w_idx % BLK];
         pend = wr_valid && wr_ready;
      end
   end

   task automatic kick(input bit wr, input bit sh, input int tmo);
      pos = 0; got_n = 0; w_idx = 0;
      @(negedge clk);
      start_wr = wr; start_short = sh; tmo_limit = TW'(tmo); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      int c = 0;
      while (!done && c < 20000) begin @(negedge clk); c++; end
      chk(done, {tag, " R8 done seen"}, done, 1);
      @(negedge clk);
      chk(!done, {tag, " R8 done one cycle"}, done, 0);
   endtask

   task automatic check_cs(input string tag, input int n);
      bit ok = 1;
      for (int i = 0; i < n - 1 && i < LOGN; i++) if (csl[i] !== 1'b0) ok = 0;
      if (n > 0 && n <= LOGN && csl[n-1] !== 1'b1) ok = 0;
      chk(ok, {tag, " R8 cs pattern"}, ok, 1);
   endtask

   task automatic do_read(input bit sh, input int h, input int tmo, input bit stall);
      int len = sh ? REG : BLK;
      bit tmo_exp = (tmo != 0) && (h >= tmo);
      int n_exp = tmo_exp ? tmo + 1 : h + 1 + len + 2 + 1;
      int k = 0;
      bit ok = 1;
      for (int i = 0; i < h; i++) begin
         logic [7:0] b = 8'($urandom);
         if (b == 8'hFE) b = 8'hFF;
         scr[k++] = b;
      end
      scr[k++] = 8'hFE;
      for (int i = 0; i < len; i++) begin
         exp_d[i] = 8'($urandom);
         scr[k++] = exp_d[i];
      end
      scr[k++] = 8'hFE; scr[k++] = 8'h5A;
      while (k < LOGN) scr[k++] = 8'hFF;
      rd_block = stall;
      kick(1'b0, sh, tmo);
      if (stall) begin
         while (!rd_valid) @(negedge clk);
         repeat (40) @(negedge clk);
         chk(pos == h + 2, "R4 no SPI byte while read byte waits", pos, h + 2);
         chk(rd_data == exp_d[0], "R4 rd_data held", rd_data, exp_d[0]);
         rd_block = 0;
      end
      wait_done("read");
      chk(err_code == (tmo_exp ? 3'd1 : 3'd0), tmo_exp ? "R9 read timeout" : "R11 read ok code",
          err_code, tmo_exp ? 1 : 0);
      chk(pos == n_exp, "R3 read byte count", pos, n_exp);
      for (int i = 0; i < pos && i < LOGN; i++) if (txl[i] != 8'hFF) ok = 0;
      chk(ok, "R2 read sends only fill bytes", ok, 1);
      check_cs("read", pos);
      chk(got_n == (tmo_exp ? 0 : len), "R3 delivered count", got_n, tmo_exp ? 0 : len);
      ok = 1;
      if (!tmo_exp) for (int i = 0; i < len; i++) if (got_d[i] != exp_d[i]) ok = 0;
      chk(ok, "R3 delivered data order", ok, 1);
   endtask

   function automatic int resp_code(input logic [7:0] r);
      case (r[4:0])
         5'h05: return 0;
         5'h0B: return 2;
         5'h0D: return 3;
         default: return 4;
      endcase
   endfunction

   task automatic do_write(input bit sh, input logic [7:0] resp, input int b, input int tmo);
      int len = sh ? REG : BLK;
      bit acc = (resp[4:0] == 5'h05);
      bit tmo_exp = acc && (tmo != 0) && (b >= tmo);
      int busy_n = !acc ? 0 : (tmo_exp ? tmo : b + 1);
      int n_exp = 1 + len + 2 + 1 + busy_n + 1;
      int ecode = tmo_exp ? 1 : resp_code(resp);
      int k = 0;
      bit ok = 1;
      for (int i = 0; i < BLK; i++) wsrc[i] = 8'($urandom);
      for (int i = 0; i < len + 3; i++) scr[k++] = 8'hFF;
      scr[k++] = resp;
      for (int i = 0; i < b; i++) scr[k++] = 8'h00;
      scr[k++] = 8'(($urandom % 255) + 1);
      while (k < LOGN) scr[k++] = 8'hFF;
      kick(1'b1, sh, tmo);
      wait_done("write");
      chk(err_code == 3'(ecode), tmo_exp ? "R9 busy timeout" : "R6 response code", err_code, ecode);
      chk(pos == n_exp, acc ? "R7 write byte count" : "R6 reject releases at once", pos, n_exp);
      chk(txl[0] == 8'hFE, "R5 start token", txl[0], 8'hFE);
      for (int i = 0; i < len; i++) if (txl[1+i] != wsrc[i]) ok = 0;
      chk(ok, "R5 write data order", ok, 1);
      ok = 1;
      for (int i = len + 1; i < pos && i < LOGN; i++) if (txl[i] != 8'hFF) ok = 0;
      chk(ok, "R5 checksum and tail fill bytes", ok, 1);
      check_cs("write", pos);
   endtask

   initial begin
      void'($urandom(32'd7));
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
      chk(!spi_req && !busy && !done && !rd_valid, "R1 reset outputs",
          {spi_req, busy, done, rd_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed reads
      do_read(1'b1, 0, 0, 1'b0);
      do_read(1'b1, 3, 0, 1'b1);
      do_read(1'b0, 2, 0, 1'b0);
      do_read(1'b1, 6, 6, 1'b0);     // R9 limit hit on the 6th miss
      do_read(1'b1, 5, 6, 1'b0);     // R9 token one before limit
      do_read(1'b1, 20, 0, 1'b0);    // R9 limit disabled
      // directed writes
      do_write(1'b1, 8'hE5, 5, 0);   // R6 upper bits ignored, R7 busy
      do_write(1'b1, 8'h0B, 3, 0);
      do_write(1'b1, 8'h0D, 3, 0);
      do_write(1'b1, 8'h07, 3, 0);
      do_write(1'b1, 8'h05, 4, 4);   // R9 busy timeout
      do_write(1'b1, 8'h05, 0, 2);
      do_write(1'b0, 8'h05, 2, 0);
      // R10: start while busy is ignored
      begin
         for (int i = 0; i < REG + 3; i++) scr[i] = 8'hFF;
         scr[REG + 3] = 8'h05; scr[REG + 4] = 8'h01;
         for (int i = REG + 5; i < LOGN; i++) scr[i] = 8'hFF;
         kick(1'b1, 1'b1, 0);
         repeat (10) @(negedge clk);
         start_wr = 1'b0; start_short = 1'b0; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         wait_done("R10");
         chk(pos == REG + 6, "R10 start during transfer ignored", pos, REG + 6);
         repeat (20) @(negedge clk);
         chk(!busy && pos == REG + 6, "R10 no extra transfer", pos, REG + 6);
         chk(err_code == 3'd0, "R11 code held after done", err_code, 0);
      end
      // constrained random mix
      for (int t = 0; t < 24; t++) begin
         bit sh = ($urandom % 6 != 0);
         if ($urandom % 2 == 0) begin
            int tmo = ($urandom % 3 == 0) ? int'($urandom % 8) : 0;
            do_read(sh, int'($urandom % 10), tmo, 1'b0);
         end else begin
            logic [7:0] r = ($urandom % 4 == 0) ? 8'($urandom) : {3'($urandom), 5'h05};
            int tmo = ($urandom % 3 == 0) ? int'($urandom % 8) : 0;
            do_write(sh, r, int'($urandom % 10), tmo);
         end
      end
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule